// File: doc/BRIEF.md
# Timer and Counter Line Allocator

This block decides which of sixteen digital I/O lines are taken over by two timers and two counters. The lines form a low group (indices 0 to 7) and a high group (indices 8 to 15). Software writes a configuration with a single strobe. The configuration holds the number of enabled timers, the two counter enables, a line offset and a clamp option. An availability flag for counter 0 is sampled with the same strobe.

On an accepted write, the enabled units are packed onto consecutive lines. The first unit sits at the effective offset, and the order is fixed: timer 0, timer 1, counter 0, counter 1. A disabled unit leaves no hole. Every line that no unit claims keeps its normal I/O role.

The block checks each write before it takes effect. A bad offset, or a run of units that would go past the last line, causes the whole write to be rejected and sets the error flag. The mapping that was in effect stays in place. Any line that a unit has ever claimed keeps a forced direction: output for a timer, input for a counter. This direction stays after the unit is released.

Top module: `tcline_alloc`

## Requirements
- R1: Enabled units occupy consecutive lines from the effective offset in the order timer 0, timer 1, counter 0, counter 1, and a disabled unit leaves no gap. Line n's owner code is `owner_map[3n+2:3n]`, with codes 0 normal I/O, 1 timer 0, 2 timer 1, 3 counter 0, 4 counter 1.
- R2: `cfg_tmr_cnt` gives the number of enabled timers. A value of 1 enables timer 0 only, and a value of 2 or 3 enables both timers.
- R3: Lines 0 to 3 never carry a unit. An offset of 0 to 3 with `cfg_clamp_low` at 0 is an error.
- R4: An offset of 0 to 3 with `cfg_clamp_low` at 1 is accepted, and the effective offset becomes 4.
- R5: An offset above `MAX_OFS` (default 8) is an error.
- R6: When `cnt0_avail` is 0 at the write, counter 0 claims no line even if it is enabled, and counter 1 moves down into its slot.
- R7: A write with an error leaves `owner_map` and the direction outputs unchanged and sets `cfg_err`. The next accepted write clears `cfg_err`.
- R8: If any enabled unit would land beyond line 15, the write is an error and is rejected as in R7.
- R9: Each line claimed by an accepted write gets its `dir_force` bit set. Its `dir_out` bit becomes 1 for a timer and 0 for a counter. Both bits persist after the unit is disabled, and `dir_force` bits never clear outside reset.
- R10: After reset, all lines are normal I/O, `dir_force` and `dir_out` are zero, and `cfg_err` is 0.
- R11: While `cfg_wr` is 0, changes on the configuration inputs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_tmr_cnt | input | 2 | Number of enabled timers |
| cfg_cnt0_en | input | 1 | Counter 0 enable |
| cfg_cnt1_en | input | 1 | Counter 1 enable |
| cfg_offset | input | 4 | Line index for the first unit |
| cfg_clamp_low | input | 1 | Clamp a low offset to 4 instead of flagging an error |
| cnt0_avail | input | 1 | Counter 0 can be used under the current clock selection |
| owner_map | output | 48 | Owner code per line, 3 bits each, line 0 in the low bits |
| dir_force | output | 16 | Line direction is overridden |
| dir_out | output | 16 | Overridden direction, 1 for output |
| cfg_err | output | 1 | Last write was rejected |

## Verification
The bench builds two copies of the block side by side. One copy uses the default `MAX_OFS` of 8. The other uses `MAX_OFS` of 15, so offsets from 9 to 15 are accepted in that copy. Only the wide copy can reach the overflow past line 15 (R8), because in the default copy no legal offset can push four units beyond line 11. Both copies receive the same writes, so one offset shows the range error in one copy and the overflow or the accepted high-group placement in the other.

// File: rtl/tcline_pkg.sv
package tcline_pkg;
  localparam int UNITS  = 4;
  localparam int SLOT_W = 6;
  localparam int OWN_W  = 3;

  typedef enum logic [OWN_W-1:0] {
    OWN_GPIO = 3'd0,
    OWN_TMR0 = 3'd1,
    OWN_TMR1 = 3'd2,
    OWN_CNT0 = 3'd3,
    OWN_CNT1 = 3'd4
  } owner_e;

  // Request vector in priority order: bit0 timer0 .. bit3 counter1
  function automatic logic [UNITS-1:0] unit_requests(input logic [1:0] tmr_cnt,
                                                     input logic c0_en,
                                                     input logic c0_avail,
                                                     input logic c1_en);
    logic [UNITS-1:0] r;
    r[0] = (tmr_cnt != 2'd0);
    r[1] = tmr_cnt[1];
    r[2] = c0_en & c0_avail;
    r[3] = c1_en;
    return r;
  endfunction

  // Line index of unit k: base plus the number of requesting units ahead of it
  function automatic logic [SLOT_W-1:0] unit_slot(input logic [SLOT_W-1:0] base,
                                                  input logic [UNITS-1:0] req,
                                                  input int k);
    logic [SLOT_W-1:0] s;
    s = base;
    for (int j = 0; j < UNITS; j++)
      if (j < k && req[j]) s = s + 1'b1;
    return s;
  endfunction

  function automatic owner_e unit_owner(input int k);
    return owner_e'(k + 1);
  endfunction
endpackage

// File: rtl/tcline_offset_chk.sv
module tcline_offset_chk #(
  parameter int OFS_W   = 4,
  parameter int MIN_OFS = 4,
  parameter int MAX_OFS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFS_W-1:0] ofs_raw,
  input  logic             clamp_low,
  output logic [OFS_W-1:0] ofs_eff,
  output logic             low_err,
  output logic             high_err
);
  localparam logic [OFS_W:0] MIN_V = (OFS_W+1)'(MIN_OFS);
  localparam logic [OFS_W:0] MAX_V = (OFS_W+1)'(MAX_OFS);

  logic below_min;

  always_comb begin
    below_min = ({1'b0, ofs_raw} < MIN_V);
    ofs_eff   = below_min ? MIN_V[OFS_W-1:0] : ofs_raw;
    low_err   = below_min & ~clamp_low;
    high_err  = ({1'b0, ofs_raw} > MAX_V);
  end

  // R3 / R4: the effective offset is never below the floor
  p_eff_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, ofs_eff} >= MIN_V))
    else $error("effective offset below floor");

  // R4: a clamped low offset is never an error
  p_clamp_no_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_low && {1'b0, ofs_raw} < MIN_V) |-> (!low_err && ofs_eff == MIN_V[OFS_W-1:0]))
    else $error("clamp did not apply");
endmodule

// File: rtl/tcline_packer.sv
module tcline_packer
  import tcline_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int OFS_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [OFS_W-1:0]           ofs_eff,
  input  logic [UNITS-1:0]           req,
  output logic [NUM_LINES*OWN_W-1:0] cand_map,
  output logic [NUM_LINES-1:0]       cand_claim,
  output logic [NUM_LINES-1:0]       cand_timer,
  output logic                       overflow
);
  logic [SLOT_W-1:0] slot [UNITS];
  logic [UNITS-1:0]  past_end;

  for (genvar k = 0; k < UNITS; k++) begin : g_slot
    always_comb begin
      slot[k]     = unit_slot(SLOT_W'(ofs_eff), req, k);
      past_end[k] = req[k] && (slot[k] >= SLOT_W'(NUM_LINES));
    end
  end

  assign overflow = |past_end;

  for (genvar ln = 0; ln < NUM_LINES; ln++) begin : g_line
    owner_e own;
    always_comb begin
      own = OWN_GPIO;
      for (int k = 0; k < UNITS; k++)
        if (req[k] && slot[k] == SLOT_W'(ln)) own = unit_owner(k);
    end
    assign cand_map[ln*OWN_W +: OWN_W] = own;
    assign cand_claim[ln] = (own != OWN_GPIO);
    assign cand_timer[ln] = (own == OWN_TMR0) || (own == OWN_TMR1);
  end

  // R1: without overflow every request lands on exactly one line
  p_claim_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !overflow |-> ($countones(cand_claim) == $countones(req)))
    else $error("claimed line count differs from request count");
endmodule

// File: rtl/tcline_dir_hold.sv
module tcline_dir_hold #(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd,
  input  logic [NUM_LINES-1:0] claim,
  input  logic [NUM_LINES-1:0] timer_line,
  output logic [NUM_LINES-1:0] force_q,
  output logic [NUM_LINES-1:0] out_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      force_q <= '0;
      out_q   <= '0;
    end else if (upd) begin
      force_q <= force_q | claim;
      out_q   <= (out_q & ~claim) | (timer_line & claim);
    end
  end

  // R9: an override, once set, is never released
  p_dir_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((force_q & $past(force_q)) == $past(force_q)))
    else $error("direction override released");

  // R9: only forced lines may report an output direction
  p_out_within_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_q & ~force_q) == '0))
    else $error("direction set on unforced line");
endmodule

// File: rtl/tcline_alloc.sv
module tcline_alloc
  import tcline_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int OFS_W     = 4,
  parameter int MIN_OFS   = 4,
  parameter int MAX_OFS   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_wr,
  input  logic [1:0]                 cfg_tmr_cnt,
  input  logic                       cfg_cnt0_en,
  input  logic                       cfg_cnt1_en,
  input  logic [OFS_W-1:0]           cfg_offset,
  input  logic                       cfg_clamp_low,
  input  logic                       cnt0_avail,
  output logic [NUM_LINES*OWN_W-1:0] owner_map,
  output logic [NUM_LINES-1:0]       dir_force,
  output logic [NUM_LINES-1:0]       dir_out,
  output logic                       cfg_err
);
  logic [OFS_W-1:0]           ofs_eff;
  logic                       low_err, high_err, overflow;
  logic [UNITS-1:0]           req;
  logic [NUM_LINES*OWN_W-1:0] cand_map;
  logic [NUM_LINES-1:0]       cand_claim, cand_timer;
  logic                       cand_err, wr_accept, wr_reject;
  logic [NUM_LINES*OWN_W-1:0] map_q;
  logic                       err_q;

  tcline_offset_chk #(.OFS_W(OFS_W), .MIN_OFS(MIN_OFS), .MAX_OFS(MAX_OFS)) u_ofs (
    .clk(clk), .rst_n(rst_n), .ofs_raw(cfg_offset), .clamp_low(cfg_clamp_low),
    .ofs_eff(ofs_eff), .low_err(low_err), .high_err(high_err));

  assign req = unit_requests(cfg_tmr_cnt, cfg_cnt0_en, cnt0_avail, cfg_cnt1_en);

  tcline_packer #(.NUM_LINES(NUM_LINES), .OFS_W(OFS_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .ofs_eff(ofs_eff), .req(req),
    .cand_map(cand_map), .cand_claim(cand_claim), .cand_timer(cand_timer),
    .overflow(overflow));

  assign cand_err  = low_err | high_err | overflow;
  assign wr_accept = cfg_wr & ~cand_err;
  assign wr_reject = cfg_wr & cand_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q <= '0;
      err_q <= 1'b0;
    end else if (cfg_wr) begin
      err_q <= cand_err;
      if (wr_accept) map_q <= cand_map;
    end
  end

  tcline_dir_hold #(.NUM_LINES(NUM_LINES)) u_dir (
    .clk(clk), .rst_n(rst_n), .upd(wr_accept), .claim(cand_claim),
    .timer_line(cand_timer), .force_q(dir_force), .out_q(dir_out));

  assign owner_map = map_q;
  assign cfg_err   = err_q;

  // R7: a rejected write leaves mapping and directions in place
  p_reject_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> ($stable(map_q) && $stable(dir_force) && $stable(dir_out) && err_q))
    else $error("rejected write changed state");

  // R11: no strobe, no change
  p_idle_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(map_q) && $stable(err_q) && $stable(dir_force)))
    else $error("state moved without write");

  // R6: an unavailable counter 0 never becomes a candidate owner
  for (genvar ln = 0; ln < NUM_LINES; ln++) begin : g_chk
    p_cnt0_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt0_avail |-> (cand_map[ln*OWN_W +: OWN_W] != OWN_CNT0))
      else $error("counter 0 placed while unavailable");
    if (ln < MIN_OFS) begin : g_low
      // R3: the lowest lines stay normal I/O
      p_low_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (map_q[ln*OWN_W +: OWN_W] == OWN_GPIO) && !dir_force[ln])
        else $error("low line claimed");
    end
  end
endmodule

// File: tb/tcline_alloc_tb.sv
module tcline_alloc_tb_top;
  localparam int NL = 16;

  typedef struct {
    logic [NL*3-1:0] map;
    logic [NL-1:0]   frc;
    logic [NL-1:0]   out;
    logic            err;
  } st_t;

  typedef struct {
    st_t   a;
    st_t   b;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_tmr_cnt = '0;
  logic cfg_cnt0_en = 1'b0, cfg_cnt1_en = 1'b0, cfg_clamp_low = 1'b0, cnt0_avail = 1'b1;
  logic [3:0] cfg_offset = 4'd4;
  logic [NL*3-1:0] map_a, map_b;
  logic [NL-1:0] frc_a, frc_b, out_a, out_b;
  logic err_a, err_b;

  int checks = 0, fails = 0;
  bit done = 0;
  item_t q[$];
  st_t ma, mb;

  always #4 clk = ~clk;

  tcline_alloc dut_i (.clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_tmr_cnt(cfg_tmr_cnt),
    .cfg_cnt0_en(cfg_cnt0_en), .cfg_cnt1_en(cfg_cnt1_en), .cfg_offset(cfg_offset),
    .cfg_clamp_low(cfg_clamp_low), .cnt0_avail(cnt0_avail), .owner_map(map_a),
    .dir_force(frc_a), .dir_out(out_a), .cfg_err(err_a));

  tcline_alloc #(.MAX_OFS(15)) dut_wide_i (.clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
    .cfg_tmr_cnt(cfg_tmr_cnt), .cfg_cnt0_en(cfg_cnt0_en), .cfg_cnt1_en(cfg_cnt1_en),
    .cfg_offset(cfg_offset), .cfg_clamp_low(cfg_clamp_low), .cnt0_avail(cnt0_avail),
    .owner_map(map_b), .dir_force(frc_b), .dir_out(out_b), .cfg_err(err_b));

  // Reference: walk a cursor across the lines, placing each enabled unit in turn
  function automatic st_t step(st_t cur, int maxo, bit wr, int tmr, bit c0, bit c1,
                               bit av, int off, bit clamp);
    st_t nx;
    bit en [4];
    int cursor;
    bit bad;
    logic [NL*3-1:0] m;
    if (!wr) return cur;
    nx = cur;
    bad = 0;
    cursor = off;
    if (off < 4) begin
      if (clamp) cursor = 4;
      else bad = 1;
    end
    if (off > maxo) bad = 1;
    en[0] = (tmr >= 1); en[1] = (tmr >= 2); en[2] = c0 && av; en[3] = c1;
    m = '0;
    for (int u = 0; u < 4; u++) begin
      if (en[u]) begin
        if (cursor > NL-1) bad = 1;
        else m[cursor*3 +: 3] = 3'(u + 1);
        cursor++;
      end
    end
    if (bad) begin
      nx.err = 1;
      return nx;
    end
    nx.map = m;
    nx.err = 0;
    for (int l = 0; l < NL; l++) begin
      if (m[l*3 +: 3] != 0) begin
        nx.frc[l] = 1;
        nx.out[l] = (m[l*3 +: 3] <= 3'd2);
      end
    end
    return nx;
  endfunction

  task automatic cmp(string tag, string what, logic [NL*3-1:0] got, logic [NL*3-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic cmp_all(string tag, st_t ea, st_t eb);
    cmp(tag, "map", map_a, ea.map);
    cmp(tag, "force", {32'h0, frc_a}, {32'h0, ea.frc});
    cmp(tag, "dir", {32'h0, out_a}, {32'h0, ea.out});
    cmp(tag, "err", {47'h0, err_a}, {47'h0, ea.err});
    cmp({tag, "/wide"}, "map", map_b, eb.map);
    cmp({tag, "/wide"}, "force", {32'h0, frc_b}, {32'h0, eb.frc});
    cmp({tag, "/wide"}, "dir", {32'h0, out_b}, {32'h0, eb.out});
    cmp({tag, "/wide"}, "err", {47'h0, err_b}, {47'h0, eb.err});
  endtask

  // Driver: sets inputs at a falling edge, pushes the expected result
  task automatic drive(string tag, bit wr, int tmr, bit c0, bit c1, bit av, int off, bit clamp);
    item_t it;
    @(negedge clk);
    cfg_wr = wr; cfg_tmr_cnt = 2'(tmr); cfg_cnt0_en = c0; cfg_cnt1_en = c1;
    cnt0_avail = av; cfg_offset = 4'(off); cfg_clamp_low = clamp;
    ma = step(ma, 8, wr, tmr, c0, c1, av, off, clamp);
    mb = step(mb, 15, wr, tmr, c0, c1, av, off, clamp);
    it.a = ma; it.b = mb; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Monitor: after the edge that takes the write, compare against the queue
  initial begin
    item_t it;
    forever begin
      wait (q.size() > 0);
      @(posedge clk);
      #1;
      it = q.pop_front();
      cmp_all(it.tag, it.a, it.b);
    end
  end

  initial begin
    ma = '{map: '0, frc: '0, out: '0, err: 1'b0};
    mb = ma;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_all("R10", ma, mb);
    drive("R1 R2 single timer", 1, 1, 0, 0, 1, 4, 0);
    drive("R1 gap closed", 1, 1, 0, 1, 1, 6, 0);
    drive("R1 high group", 1, 2, 1, 1, 1, 8, 0);
    drive("R2 R6 cnt0 gated", 1, 3, 1, 1, 0, 5, 0);
    drive("R3 R7 low offset", 1, 2, 0, 0, 1, 2, 0);
    drive("R4 clamp", 1, 0, 1, 0, 1, 1, 1);
    drive("R5 offset 9", 1, 2, 0, 1, 1, 9, 0);
    drive("R8 overflow", 1, 2, 1, 1, 1, 13, 0);
    drive("R5 R8 last line", 1, 0, 0, 1, 1, 15, 0);
    drive("R11 no strobe", 0, 2, 1, 1, 1, 4, 0);
    drive("R3 zero offset", 1, 0, 0, 0, 1, 0, 0);
    drive("R9 all released", 1, 0, 0, 0, 1, 4, 0);
    drive("R11 idle clamp", 0, 1, 0, 0, 1, 0, 1);
    drive("R1 R9 full set", 1, 2, 1, 1, 1, 4, 0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule